// File: doc/BRIEF.md
# Bayer Row Horizontal Bin/Skip Unit

This unit takes one streamed row of Bayer-mosaic pixels at a time and can halve its horizontal resolution. A Bayer row alternates two colour planes on every pixel. The unit therefore collects pixels in groups of four (colour A, colour B, colour A, colour B) and always pairs pixels of the same colour, which sit two positions apart. In bin mode each same-colour pair is replaced by its rounded average. In skip mode the first pair of each group is kept and the second pair is dropped. In both reduced modes the output row still alternates A, B at half width.

Row timing is preserved. The output has one beat per valid input beat in normal mode, or two beats per complete group in a reduced mode, with idle cycles in between. Start-of-row and end-of-row markers travel with the first and last output pixels. The mode input is sampled on the start-of-row beat and then held for the whole row. A row whose length is not a multiple of four is flagged through a sticky error output, and in a reduced mode its trailing partial group is discarded.

Top module: `bayer_hbin`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after a reset edge, out_valid, out_sor, out_eor and err_len are all low.
- R2: In normal mode (mode codes 0 and 3), every input pixel appears unchanged on out_data, in order. Its out_valid is high exactly two clock cycles after the input beat is sampled, and its start and end markers are copied with it.
- R3: In bin mode (code 1), the valid beats of a row are numbered from 0 at the start-of-row beat. Each group at positions 4k..4k+3 (p0..p3) yields (p0+p2+1)>>1 and then (p1+p3+1)>>1, both at the pixel width. The first result is valid in the cycle right after p3 is sampled, and the second in the following cycle.
- R4: In skip mode (code 2), each complete group yields p0 and then p1, with the same timing as R3. p2 and p3 never appear.
- R5: In a reduced mode, out_sor is set on the first output of a row. out_eor is set on the second output of the last group, but only when the row's final beat is at position 3 of its group. Neither marker is ever high without out_valid.
- R6: mode_cfg is sampled only on the start-of-row beat. Changes later in the same row have no effect on that row.
- R7: In a reduced mode, a trailing group with fewer than four pixels produces no output, and that row gets no out_eor. In normal mode, all pixels of such a row are passed through.
- R8: err_len goes high when an end-of-row beat falls on a group position other than 3, in any mode. It stays high until reset. Rows whose length is a multiple of four never set it.
- R9: Idle cycles (in_valid low) inside a row do not change the grouping or the output values, because positions count valid beats only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 2 | Row mode: 0 normal, 1 bin 2x, 2 skip 2x, 3 treated as normal |
| in_valid | input | 1 | Input pixel beat valid |
| in_data | input | PIX_W | Input pixel value |
| in_sor | input | 1 | Marks the first pixel of a row |
| in_eor | input | 1 | Marks the last pixel of a row |
| out_valid | output | 1 | Output pixel beat valid |
| out_data | output | PIX_W | Output pixel value |
| out_sor | output | 1 | First output pixel of a row |
| out_eor | output | 1 | Last output pixel of a row |
| err_len | output | 1 | Sticky flag for a row length that is not a multiple of four |

## Verification
A group phase that slips by one position shows up within one group. The bin results mix the wrong colours or arrive at the wrong beat, and in skip mode the discarded pixels appear instead of the kept ones. A row mode latched at the wrong beat changes the output count and values of that same row, so the row-by-row comparison exposes it before the row ends. A stuck or lost pending second output shows up as a missing or extra beat one cycle after a group completes, and a wrong error flag is visible directly on err_len after the offending end-of-row beat.

// File: rtl/hbin_pkg.sv
package hbin_pkg;

    typedef enum logic [1:0] {
        HB_NORMAL = 2'd0,
        HB_BIN    = 2'd1,
        HB_SKIP   = 2'd2
    } hb_mode_e;

    localparam int unsigned HB_GROUP = 4;
    localparam int unsigned HB_PH_W  = $clog2(HB_GROUP);

    typedef logic [HB_PH_W-1:0] hb_phase_t;

    localparam hb_phase_t HB_LAST_PH = hb_phase_t'(HB_GROUP - 1);

    // Unused code 3 falls back to pass-through.
    function automatic hb_mode_e hb_decode(input logic [1:0] code);
        case (code)
            2'd1:    return HB_BIN;
            2'd2:    return HB_SKIP;
            default: return HB_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/hbin_track.sv
module hbin_track
    import hbin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [1:0] mode_cfg,
    input  logic      in_valid,
    input  logic      in_sor,
    input  logic      in_eor,
    output hb_phase_t cur_ph,
    output hb_mode_e  cur_mode,
    output logic      grp_first,
    output logic      err_len
);

    hb_phase_t ph_q;
    hb_mode_e  mode_q;
    logic      first_q;
    logic      err_q;

    // A start-of-row beat always opens position 0 and loads the row mode.
    assign cur_ph    = in_sor ? '0 : ph_q;
    assign cur_mode  = in_sor ? hb_decode(mode_cfg) : mode_q;
    assign grp_first = first_q;
    assign err_len   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= '0;
            mode_q  <= HB_NORMAL;
            first_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (in_valid) begin
            ph_q <= cur_ph + hb_phase_t'(1);
            if (in_sor) begin
                mode_q  <= hb_decode(mode_cfg);
                first_q <= 1'b1;
            end else if (cur_ph == HB_LAST_PH) begin
                first_q <= 1'b0;
            end
            if (in_eor && (cur_ph != HB_LAST_PH)) begin
                err_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hbin_group.sv
module hbin_group
    import hbin_pkg::*;
#(
    parameter int unsigned PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    input  hb_phase_t        cur_ph,
    input  hb_mode_e         cur_mode,
    output logic             grp_done,
    output logic [PIX_W-1:0] res_a,
    output logic [PIX_W-1:0] res_b
);

    localparam int unsigned HOLD = HB_GROUP - 1;
    localparam int unsigned PAIR = HB_GROUP / 2;

    logic [PIX_W-1:0] slot_q [HOLD];

    function automatic logic [PIX_W-1:0] avg2(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b);
        logic [PIX_W:0] s;
        s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
        return s[PIX_W:1];
    endfunction

    // One capture register per non-final group position.
    for (genvar g = 0; g < HOLD; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (in_valid && (cur_ph == hb_phase_t'(g))) begin
                slot_q[g] <= in_data;
            end
        end
    end

    assign grp_done = in_valid && (cur_ph == HB_LAST_PH);

    always_comb begin
        if (cur_mode == HB_BIN) begin
            res_a = avg2(slot_q[0], slot_q[PAIR]);
            res_b = avg2(slot_q[1], in_data);
        end else begin
            res_a = slot_q[0];
            res_b = slot_q[1];
        end
    end

endmodule

// File: rtl/hbin_emit.sv
module hbin_emit
    import hbin_pkg::*;
#(
    parameter int unsigned PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_sor,
    input  logic             in_eor,
    input  hb_mode_e         cur_mode,
    input  logic             grp_done,
    input  logic             grp_first,
    input  logic [PIX_W-1:0] res_a,
    input  logic [PIX_W-1:0] res_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sor,
    output logic             out_eor
);

    typedef struct packed {
        logic             v;
        logic             s;
        logic             e;
        logic [PIX_W-1:0] d;
    } beat_t;

    beat_t dly_q;
    beat_t pend_q;
    beat_t out_q;

    logic norm_take;
    logic red_take;

    assign norm_take = in_valid && (cur_mode == HB_NORMAL);
    assign red_take  = grp_done && (cur_mode != HB_NORMAL);

    // Normal beats pass through dly_q (two cycles); a finished reduced
    // group drives out_q at once and parks its second result in pend_q.
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q  <= '0;
            pend_q <= '0;
            out_q  <= '0;
        end else begin
            dly_q  <= '{v: norm_take, s: in_sor, e: in_eor, d: in_data};
            pend_q <= '{v: red_take, s: 1'b0, e: in_eor, d: res_b};
            if (red_take) begin
                out_q <= '{v: 1'b1, s: grp_first, e: 1'b0, d: res_a};
            end else if (pend_q.v) begin
                out_q <= pend_q;
            end else if (dly_q.v) begin
                out_q <= dly_q;
            end else begin
                out_q <= '{v: 1'b0, s: 1'b0, e: 1'b0, d: out_q.d};
            end
        end
    end

    assign out_valid = out_q.v;
    assign out_data  = out_q.d;
    assign out_sor   = out_q.s;
    assign out_eor   = out_q.e;

endmodule

// File: rtl/bayer_hbin.sv
module bayer_hbin
    import hbin_pkg::*;
#(
    parameter int unsigned PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_cfg,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_sor,
    input  logic             in_eor,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sor,
    output logic             out_eor,
    output logic             err_len
);

    hb_phase_t        cur_ph;
    hb_mode_e         cur_mode;
    logic             grp_first;
    logic             grp_done;
    logic [PIX_W-1:0] res_a;
    logic [PIX_W-1:0] res_b;

    hbin_track u_track (
        .clk       (clk),
        .rst       (rst),
        .mode_cfg  (mode_cfg),
        .in_valid  (in_valid),
        .in_sor    (in_sor),
        .in_eor    (in_eor),
        .cur_ph    (cur_ph),
        .cur_mode  (cur_mode),
        .grp_first (grp_first),
        .err_len   (err_len)
    );

    hbin_group #(.PIX_W(PIX_W)) u_group (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cur_ph   (cur_ph),
        .cur_mode (cur_mode),
        .grp_done (grp_done),
        .res_a    (res_a),
        .res_b    (res_b)
    );

    hbin_emit #(.PIX_W(PIX_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sor    (in_sor),
        .in_eor    (in_eor),
        .cur_mode  (cur_mode),
        .grp_done  (grp_done),
        .grp_first (grp_first),
        .res_a     (res_a),
        .res_b     (res_b),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sor   (out_sor),
        .out_eor   (out_eor)
    );

endmodule

// File: rtl/bayer_hbin_chk.sv
module bayer_hbin_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_sor,
    input logic in_eor,
    input logic out_valid,
    input logic out_sor,
    input logic out_eor,
    input logic err_len
);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !err_len && !out_sor && !out_eor));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_len |=> err_len);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_len) |-> $past(in_valid && in_eor));

    // R5
    marker_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sor || out_eor) |-> out_valid);

    // R2 R3 R4
    out_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) || $past(in_valid, 2)));

    // R5
    sor_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_sor |-> ($past(in_valid) || $past(in_valid && in_sor, 2)));

endmodule

bind bayer_hbin bayer_hbin_chk u_chk (.*);

// File: tb/bayer_hbin_bench.sv
module bayer_hbin_bench;

    localparam int PIX_W = 12;
    localparam int MASK  = (1 << PIX_W) - 1;

    typedef struct packed {
        logic [1:0] mode;
        logic       chg;
        logic [1:0] alt;
        logic       gap;
        logic [7:0] len;
        logic [7:0] seed;
    } row_t;

    localparam int NROWS = 8;
    localparam row_t ROWS [0:NROWS-1] = '{
        '{2'd0, 1'b0, 2'd0, 1'b0, 8'd8,  8'd3},
        '{2'd1, 1'b0, 2'd0, 1'b0, 8'd8,  8'd5},
        '{2'd2, 1'b0, 2'd0, 1'b0, 8'd12, 8'd7},
        '{2'd1, 1'b0, 2'd0, 1'b1, 8'd8,  8'd9},
        '{2'd2, 1'b1, 2'd1, 1'b0, 8'd8,  8'd11},
        '{2'd3, 1'b0, 2'd0, 1'b0, 8'd4,  8'd13},
        '{2'd1, 1'b1, 2'd0, 1'b0, 8'd12, 8'd17},
        '{2'd2, 1'b0, 2'd0, 1'b1, 8'd16, 8'd19}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode_cfg = 2'd0;
    logic             in_valid = 1'b0;
    logic [PIX_W-1:0] in_data = '0;
    logic             in_sor = 1'b0;
    logic             in_eor = 1'b0;
    logic             out_valid;
    logic [PIX_W-1:0] out_data;
    logic             out_sor;
    logic             out_eor;
    logic             err_len;

    always #5 clk = ~clk;

    bayer_hbin #(.PIX_W(PIX_W)) u_bayer_hbin (
        .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .in_valid(in_valid),
        .in_data(in_data), .in_sor(in_sor), .in_eor(in_eor),
        .out_valid(out_valid), .out_data(out_data), .out_sor(out_sor),
        .out_eor(out_eor), .err_len(err_len)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    int    exp_d [0:1023];
    bit    exp_s [0:1023];
    bit    exp_e [0:1023];
    bit    exp_red [0:1023];
    string exp_r [0:1023];
    int    wr = 0;
    int    rd = 0;
    int    rowbuf [0:63];

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic push(input int d, input bit s, input bit e, input bit red, input string req);
        exp_d[wr] = d; exp_s[wr] = s; exp_e[wr] = e; exp_red[wr] = red; exp_r[wr] = req;
        wr++;
    endtask

    // Output monitor, sampled away from the rising edge.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd == wr) begin
                check("R7", 1, 0, "unexpected output beat");
            end else begin
                check(exp_r[rd], int'(out_data), exp_d[rd], "data");
                check(exp_red[rd] ? "R5" : exp_r[rd], int'(out_sor), int'(exp_s[rd]), "sor");
                check(exp_red[rd] ? "R5" : exp_r[rd], int'(out_eor), int'(exp_e[rd]), "eor");
                rd++;
            end
        end
    end

    task automatic expect_row(input logic [1:0] mode, input int len, input string tag);
        bit red;
        bit bin;
        int groups;
        red = (mode == 2'd1) || (mode == 2'd2);
        bin = (mode == 2'd1);
        if (red) begin
            groups = len / 4;
            for (int g = 0; g < groups; g++) begin
                for (int k = 0; k < 2; k++) begin
                    int d;
                    d = bin ? ((rowbuf[4*g+k] + rowbuf[4*g+k+2] + 1) >> 1) : rowbuf[4*g+k];
                    push(d, (g == 0) && (k == 0),
                         (len % 4 == 0) && (g == groups - 1) && (k == 1), 1'b1,
                         tag != "" ? tag : (bin ? "R3" : "R4"));
                end
            end
        end else begin
            for (int i = 0; i < len; i++) begin
                push(rowbuf[i], i == 0, i == len - 1, 1'b0, tag != "" ? tag : "R2");
            end
        end
    endtask

    task automatic drive_row(input logic [1:0] mode, input bit chg, input logic [1:0] alt,
                             input bit gap, input int len);
        mode_cfg = mode;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = PIX_W'(rowbuf[i]);
            in_sor   = (i == 0);
            in_eor   = (i == len - 1);
            @(negedge clk);
            if (i == 0 && chg) mode_cfg = alt;
            if (gap && (i % 3 == 1)) begin
                in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0, "out_valid in reset");
        check("R1", int'(out_sor), 0, "out_sor in reset");
        check("R1", int'(out_eor), 0, "out_eor in reset");
        check("R1", int'(err_len), 0, "err_len in reset");
        rst = 1'b0;
        @(negedge clk);

        // Table walk: R2 R3 R4 R6 R9
        for (int r = 0; r < NROWS; r++) begin
            string tag;
            for (int i = 0; i < int'(ROWS[r].len); i++)
                rowbuf[i] = (int'(ROWS[r].seed) * 389 + i * 1237 + i * i * 7) & MASK;
            tag = ROWS[r].chg ? "R6" : (ROWS[r].gap ? "R9" : "");
            expect_row(ROWS[r].mode, int'(ROWS[r].len), tag);
            drive_row(ROWS[r].mode, ROWS[r].chg, ROWS[r].alt, ROWS[r].gap, int'(ROWS[r].len));
        end
        check("R8", int'(err_len), 0, "err_len after whole-group rows");
        check("R2", rd, wr, "outputs drained after table");

        // R3 rounding at range extremes
        rowbuf[0] = 4095; rowbuf[1] = 0; rowbuf[2] = 4094; rowbuf[3] = 1;
        rowbuf[4] = 1; rowbuf[5] = 4095; rowbuf[6] = 0; rowbuf[7] = 4094;
        expect_row(2'd1, 8, "R3");
        drive_row(2'd1, 1'b0, 2'd0, 1'b0, 8);

        // R3 latency: first result right after 4th beat, second next cycle
        for (int i = 0; i < 4; i++) rowbuf[i] = 100 * (i + 1);
        expect_row(2'd1, 4, "R3");
        mode_cfg = 2'd1;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_data = PIX_W'(rowbuf[i]);
            in_sor = (i == 0); in_eor = (i == 3);
            @(negedge clk);
            if (i < 3) check("R3", int'(out_valid), 0, "no output before group done");
        end
        in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;
        check("R3", int'(out_valid), 1, "first result timing");
        @(negedge clk);
        check("R3", int'(out_valid), 1, "second result timing");
        @(negedge clk);
        check("R3", int'(out_valid), 0, "idle after group");
        repeat (2) @(negedge clk);

        // R2 latency: two cycles in normal mode
        for (int i = 0; i < 4; i++) rowbuf[i] = 7 + i;
        expect_row(2'd0, 4, "R2");
        mode_cfg = 2'd0;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_data = PIX_W'(rowbuf[i]);
            in_sor = (i == 0); in_eor = (i == 3);
            @(negedge clk);
            if (i == 0) check("R2", int'(out_valid), 0, "no output one cycle after beat");
            if (i == 1) check("R2", int'(out_valid), 1, "output two cycles after beat");
        end
        in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;
        repeat (4) @(negedge clk);

        // R7 R8: incomplete trailing groups
        for (int i = 0; i < 6; i++) rowbuf[i] = 50 + 3 * i;
        expect_row(2'd1, 6, "R7");
        drive_row(2'd1, 1'b0, 2'd0, 1'b0, 6);
        check("R8", int'(err_len), 1, "err_len after 6-beat row");
        check("R7", rd, wr, "partial group dropped in bin");
        expect_row(2'd2, 3, "R7");
        drive_row(2'd2, 1'b0, 2'd0, 1'b0, 3);
        check("R7", rd, wr, "short row silent in skip");
        expect_row(2'd0, 5, "R7");
        drive_row(2'd0, 1'b0, 2'd0, 1'b0, 5);
        check("R7", rd, wr, "normal passes partial row");
        for (int i = 0; i < 4; i++) rowbuf[i] = 9 * i;
        expect_row(2'd2, 4, "R4");
        drive_row(2'd2, 1'b0, 2'd0, 1'b0, 4);
        check("R8", int'(err_len), 1, "err_len sticky after good row");

        // R1: reset clears the flag
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", int'(err_len), 0, "err_len cleared by reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R5", rd, wr, "all expected outputs seen");
        finish_run();
    end

endmodule